// File: doc/BRIEF.md
# SPI Data Buffer Front-End

This block sits between a simple memory-mapped register port and an SPI shift engine. Software pushes outgoing words through a write-only transmit data address and collects incoming words through a read-only receive data address. Both directions are buffered: either by a single holding register or, when the FIFO option is chosen, by a queue of configurable depth. The word width is a parameter (8, 16 or 32 bits) and is never wider than the bus. When the word is narrower, the upper bus bits are ignored on writes and read back as zero.

A small sequencer decides when the shift engine may take the next word. In master mode this happens once the SPI enable input is high. In slave mode it happens once the active-low select input is low. The sequencer has three states. SEQ_IDLE waits for data and permission; the transition SEQ_IDLE to SEQ_SHIFT loads a word. SEQ_SHIFT covers the serial transfer; the transition SEQ_SHIFT to SEQ_HANDOFF fires on the engine's completion pulse, which captures the received word and releases the sent one. SEQ_HANDOFF either starts the next word at once (SEQ_HANDOFF to SEQ_SHIFT) or returns to SEQ_IDLE (SEQ_HANDOFF to SEQ_IDLE).

The receive side cannot throttle the link. A word that completes while the receive buffer is full, and is not being read in that same cycle, is thrown away. The older buffered words are kept, and a one-cycle overrun interrupt is raised.

Top module: `spi_data_frontend`

## Requirements
- R1: After a synchronous active-high reset, the transmit buffer is empty (tx_empty=1, tx_full=0). The receive buffer is empty (rx_full=0). busy, shift_load and irq_overrun are all 0.
- R2: A write to offset 0x68 stores bits WORD_W-1:0 of acc_wdata. Stored words reach shift_word in write order, bit for bit, so bus bit WORD_W-1 is always the most significant bit of the word.
- R3: A word is handed to the shift engine only when permission is given. In master mode (master_mode=1) permission needs spi_enable=1. In slave mode (master_mode=0) it needs slave_sel_n=0. Without permission, shift_load stays 0 and the buffer is unchanged.
- R4: shift_load pulses for one cycle when the sequencer is not busy, permission is given and the transmit buffer is not empty. busy is 1 from the next cycle until the cycle of xfer_done. That xfer_done releases the word from the buffer. The next word can be loaded in the following cycle.
- R5: A write to 0x68 while tx_full=1 gives acc_err=1 in the same cycle, and the word is discarded. Every other access gives acc_err=0.
- R6: A read of 0x68 returns zero, gives no error and changes nothing.
- R7: On xfer_done in a transfer, rx_word is stored if the receive buffer has space. A read of 0x6C returns the oldest stored word zero-extended to the bus width, and removes that word.
- R8: If xfer_done completes a transfer while rx_full=1 and no read of 0x6C happens in that cycle, the new word is dropped and irq_overrun is 1 for exactly the next cycle. A read of 0x6C in the same cycle frees space, and the word is then kept.
- R9: A read of 0x6C with the receive buffer empty returns zero with acc_err=0. A write to 0x6C returns acc_err=0 and leaves the receive buffer unchanged.
- R10: xfer_done while no transfer is active (busy=0) is ignored.
- R11: tx_full, tx_empty and rx_full follow the buffer occupancy. The depth is FIFO_DEPTH when USE_FIFO=1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_addr | input | 8 | Register byte offset |
| acc_wdata | input | BUS_W | Write data |
| acc_rdata | output | BUS_W | Read data, valid in the strobe cycle |
| acc_err | output | 1 | Error response, valid in the strobe cycle |
| master_mode | input | 1 | 1 = master role, 0 = slave role |
| spi_enable | input | 1 | Master transfer permission |
| slave_sel_n | input | 1 | Active-low slave select |
| shift_load | output | 1 | Pulse: shift engine takes shift_word |
| shift_word | output | WORD_W | Word offered to the shift engine |
| xfer_done | input | 1 | Pulse from engine: current word finished |
| rx_word | input | WORD_W | Word received during the finished transfer |
| busy | output | 1 | A transfer is in progress |
| tx_full | output | 1 | Transmit buffer full |
| tx_empty | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive buffer full |
| irq_overrun | output | 1 | One-cycle pulse per dropped received word |

## Verification
The hardest case to reach is a completion that lands while the receive buffer is full. It matters most when a read of the receive address arrives in that same cycle: the word must then be kept, not dropped. To get there, the bench first lets sixteen transfers fill the receive side without any reads, so further completions overrun. It then runs transfers with a receive read placed exactly on each completion cycle. A reference model built from queues is compared against the design on every clock throughout.

// File: rtl/spi_dfe_pkg.sv
package spi_dfe_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_SHIFT   = 2'd1,
        SEQ_HANDOFF = 2'd2
    } seq_state_t;

    localparam logic [7:0] TXD_OFFSET = 8'h68;
    localparam logic [7:0] RXD_OFFSET = 8'h6C;

endpackage

// File: rtl/spi_dfe_buf.sv
module spi_dfe_buf #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    generate
        if (DEPTH == 1) begin : g_single
            logic [W-1:0] slot;
            logic         valid;
            logic         do_pop;
            logic         do_push;

            assign do_pop  = pop && valid;
            assign do_push = push && (!valid || do_pop);

            always_ff @(posedge clk) begin
                if (rst) begin
                    slot  <= '0;
                    valid <= 1'b0;
                end else begin
                    if (do_push) begin
                        slot  <= din;
                        valid <= 1'b1;
                    end else if (do_pop) begin
                        valid <= 1'b0;
                    end
                end
            end

            assign dout  = slot;
            assign full  = valid;
            assign empty = !valid;

            // R5: a refused push leaves the register untouched
            assert_single_drop_R5: assert property (@(posedge clk) disable iff (rst)
                (push && valid && !pop) |=> (slot == $past(slot)));
        end else begin : g_queue
            logic [W-1:0]  mem [DEPTH];
            logic [AW-1:0] rd_ptr;
            logic [AW-1:0] wr_ptr;
            logic [CW-1:0] cnt;
            logic          do_pop;
            logic          do_push;

            function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
                return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
            endfunction

            assign do_pop  = pop && (cnt != '0);
            assign do_push = push && ((cnt != CW'(DEPTH)) || do_pop);

            always_ff @(posedge clk) begin
                if (rst) begin
                    rd_ptr <= '0;
                    wr_ptr <= '0;
                    cnt    <= '0;
                    for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
                end else begin
                    if (do_push) begin
                        mem[wr_ptr] <= din;
                        wr_ptr      <= wrap_inc(wr_ptr);
                    end
                    if (do_pop) rd_ptr <= wrap_inc(rd_ptr);
                    unique case ({do_push, do_pop})
                        2'b10:   cnt <= cnt + 1'b1;
                        2'b01:   cnt <= cnt - 1'b1;
                        default: cnt <= cnt;
                    endcase
                end
            end

            assign dout  = mem[rd_ptr];
            assign full  = (cnt == CW'(DEPTH));
            assign empty = (cnt == '0);

            // R11: occupancy never exceeds the configured depth
            assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (rst)
                cnt <= CW'(DEPTH));
            // R5: a push into a full queue without a pop leaves occupancy as is
            assert_drop_keeps_count_R5: assert property (@(posedge clk) disable iff (rst)
                (push && full && !pop) |=> (cnt == $past(cnt)));
        end
    endgenerate

endmodule

// File: rtl/spi_dfe_seq.sv
module spi_dfe_seq
    import spi_dfe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic tx_empty,
    input  logic xfer_done,
    output logic shift_load,
    output logic tx_release,
    output logic rx_capture,
    output logic busy
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:    if (go && !tx_empty) state_d = SEQ_SHIFT;
            SEQ_SHIFT:   if (xfer_done)       state_d = SEQ_HANDOFF;
            SEQ_HANDOFF: state_d = (go && !tx_empty) ? SEQ_SHIFT : SEQ_IDLE;
            default:     state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        shift_load = 1'b0;
        tx_release = 1'b0;
        rx_capture = 1'b0;
        busy       = 1'b0;
        unique case (state_q)
            SEQ_IDLE, SEQ_HANDOFF: shift_load = go && !tx_empty;
            SEQ_SHIFT: begin
                busy       = 1'b1;
                tx_release = xfer_done;
                rx_capture = xfer_done;
            end
            default: ;
        endcase
    end

    // R4: a word is released only while the buffer still holds it
    assert_release_has_word_R4: assert property (@(posedge clk) disable iff (rst)
        tx_release |-> !tx_empty);
    // R4: a load is followed by a busy cycle
    assert_load_then_busy_R4: assert property (@(posedge clk) disable iff (rst)
        shift_load |=> busy);
    // R10: completion outside a transfer does not create a capture
    assert_idle_done_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !busy) |-> !rx_capture);

endmodule

// File: rtl/spi_data_frontend.sv
module spi_data_frontend
    import spi_dfe_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int BUS_W      = 32,
    parameter int USE_FIFO   = 1,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [7:0]        acc_addr,
    input  logic [BUS_W-1:0]  acc_wdata,
    output logic [BUS_W-1:0]  acc_rdata,
    output logic              acc_err,
    input  logic              master_mode,
    input  logic              spi_enable,
    input  logic              slave_sel_n,
    output logic              shift_load,
    output logic [WORD_W-1:0] shift_word,
    input  logic              xfer_done,
    input  logic [WORD_W-1:0] rx_word,
    output logic              busy,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              irq_overrun
);

    localparam int BUF_DEPTH = (USE_FIFO != 0) ? FIFO_DEPTH : 1;

    logic              go;
    logic              tx_wr_hit;
    logic              rx_rd_hit;
    logic              tx_release;
    logic              rx_capture;
    logic              rx_empty;
    logic [WORD_W-1:0] rx_head;
    logic              ovr_q;

    assign go        = master_mode ? spi_enable : !slave_sel_n;
    assign tx_wr_hit = acc_wr && (acc_addr == TXD_OFFSET);
    assign rx_rd_hit = acc_rd && (acc_addr == RXD_OFFSET);

    spi_dfe_buf #(.W(WORD_W), .DEPTH(BUF_DEPTH)) u_txbuf (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_wr_hit && !tx_full),
        .pop   (tx_release),
        .din   (acc_wdata[WORD_W-1:0]),
        .dout  (shift_word),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_dfe_buf #(.W(WORD_W), .DEPTH(BUF_DEPTH)) u_rxbuf (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_capture),
        .pop   (rx_rd_hit),
        .din   (rx_word),
        .dout  (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_dfe_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .tx_empty   (tx_empty),
        .xfer_done  (xfer_done),
        .shift_load (shift_load),
        .tx_release (tx_release),
        .rx_capture (rx_capture),
        .busy       (busy)
    );

    assign acc_err   = tx_wr_hit && tx_full;
    assign acc_rdata = (rx_rd_hit && !rx_empty) ? BUS_W'(rx_head) : '0;

    always_ff @(posedge clk) begin
        if (rst) ovr_q <= 1'b0;
        else     ovr_q <= rx_capture && rx_full && !rx_rd_hit;
    end

    assign irq_overrun = ovr_q;

    // R8: one pulse per dropped word, never two in a row
    assert_overrun_single_R8: assert property (@(posedge clk) disable iff (rst)
        irq_overrun |=> !irq_overrun);
    // R8: an overrun can only follow a full receive buffer
    assert_overrun_after_full_R8: assert property (@(posedge clk) disable iff (rst)
        irq_overrun |-> $past(rx_full));
    // R3: without permission no word leaves the transmit buffer
    assert_no_load_without_go_R3: assert property (@(posedge clk) disable iff (rst)
        (master_mode && !spi_enable) |-> !shift_load);
    // R6: reads of the transmit address never return data
    assert_tx_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && acc_addr == TXD_OFFSET) |-> (acc_rdata == '0 && !acc_err));

endmodule

// File: tb/spi_data_frontend_test.sv
module spi_data_frontend_test;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_wr, acc_rd;
    logic [7:0]  acc_addr;
    logic [31:0] acc_wdata;
    logic [31:0] acc_rdata;
    logic        acc_err;
    logic        master_mode, spi_enable, slave_sel_n;
    logic        shift_load;
    logic [7:0]  shift_word;
    logic        xfer_done;
    logic [7:0]  rx_word;
    logic        busy, tx_full, tx_empty, rx_full, irq_overrun;

    always #5 clk = ~clk;

    spi_data_frontend uut (
        .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err),
        .master_mode(master_mode), .spi_enable(spi_enable), .slave_sel_n(slave_sel_n),
        .shift_load(shift_load), .shift_word(shift_word), .xfer_done(xfer_done),
        .rx_word(rx_word), .busy(busy), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_full(rx_full), .irq_overrun(irq_overrun)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    int  ph = 0;
    bit  ovr_pend = 0;
    int  dly = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        acc_wr = 0; acc_rd = 0; acc_addr = 8'h00; acc_wdata = '0;
        xfer_done = 0; rx_word = 8'h00;
    endtask

    task automatic cyc(input bit first);
        bit go_m, exp_load, exp_err, cap, rxpop, newov, txfull_b;
        logic [31:0] exp_rd;
        bit w, r, dn;
        logic [7:0] a, rw;
        logic [31:0] wd;
        string tl, tb, tr, te, tf;
        #1;
        w = acc_wr; r = acc_rd; a = acc_addr; wd = acc_wdata; dn = xfer_done; rw = rx_word;
        go_m     = master_mode ? spi_enable : !slave_sel_n;
        exp_load = (ph != 1) && go_m && (txq.size() > 0);
        exp_err  = w && (a == 8'h68) && (txq.size() == D);
        exp_rd   = (r && a == 8'h6C && rxq.size() > 0) ? {24'h0, rxq[0]} : 32'h0;
        tl = go_m ? "R4" : "R3";
        tb = (dn && ph != 1) ? "R10" : "R4";
        tr = (r && a == 8'h68) ? "R6" : ((r && a == 8'h6C && rxq.size() == 0) ? "R9" : "R7");
        te = (w && a == 8'h6C) ? "R9" : ((r && a == 8'h68) ? "R6" : "R5");
        tf = first ? "R1" : "R11";
        chk(tl, "shift_load", 32'(shift_load), 32'(exp_load));
        if (exp_load) chk("R2", "shift_word", 32'(shift_word), 32'(txq[0]));
        chk(tb, "busy", 32'(busy), 32'(ph == 1));
        chk(te, "acc_err", 32'(acc_err), 32'(exp_err));
        chk(tr, "acc_rdata", acc_rdata, exp_rd);
        chk(tf, "tx_full", 32'(tx_full), 32'(txq.size() == D));
        chk(tf, "tx_empty", 32'(tx_empty), 32'(txq.size() == 0));
        chk(tf, "rx_full", 32'(rx_full), 32'(rxq.size() == D));
        chk(first ? "R1" : "R8", "irq_overrun", 32'(irq_overrun), 32'(ovr_pend));
        @(posedge clk);
        cap   = (ph == 1) && dn;
        rxpop = r && (a == 8'h6C) && (rxq.size() > 0);
        newov = cap && (rxq.size() == D) && !rxpop;
        if (rxpop) void'(rxq.pop_front());
        if (cap && rxq.size() < D) rxq.push_back(rw);
        txfull_b = (txq.size() == D);
        if (cap) void'(txq.pop_front());
        if (w && a == 8'h68 && !txfull_b) txq.push_back(wd[7:0]);
        case (ph)
            0:       if (exp_load) ph = 1;
            1:       if (dn) ph = 2;
            default: ph = exp_load ? 1 : 0;
        endcase
        ovr_pend = newov;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        acc_wr = 1; acc_addr = a; acc_wdata = d; cyc(0);
    endtask

    task automatic rd(input logic [7:0] a);
        acc_rd = 1; acc_addr = a; cyc(0);
    endtask

    // rd_mode: 0 none, 1 read receive address on completion cycles, 2 read every cycle
    task automatic run(input int n, input bit auto_done, input int rd_mode);
        for (int i = 0; i < n; i++) begin
            if (auto_done && ph == 1) begin
                dly++;
                if (dly == 3) begin
                    xfer_done = 1; dly = 0;
                    rx_word = 8'($urandom);
                end
            end
            if ((rd_mode == 1 && xfer_done) || rd_mode == 2) begin
                acc_rd = 1; acc_addr = 8'h6C;
            end
            cyc(0);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        master_mode = 1; spi_enable = 0; slave_sel_n = 1;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        cyc(1);                                     // R1 reset state

        // R3 / R10: data present, no permission, stray completions ignored
        wr(8'h68, 32'hDEAD_BEA5);
        wr(8'h68, 32'h1234_5680);
        wr(8'h68, 32'hFFFF_FF01);
        xfer_done = 1; cyc(0);                      // R10
        run(4, 0, 0);

        // R11 / R5: fill, then overfill
        for (int i = 0; i < D - 3; i++) wr(8'h68, $urandom);
        wr(8'h68, 32'hAAAA_AA77);                   // R5 error
        wr(8'h68, 32'h5555_5566);                   // R5 error
        rd(8'h68);                                  // R6
        wr(8'h6C, 32'h0000_00FF);                   // R9
        rd(8'h6C);                                  // R9 empty read

        // R4 / R2 / R7: master transfers, receive fills without reads
        spi_enable = 1;
        run(80, 1, 0);
        // R8: overruns with a full receive side
        for (int i = 0; i < 3; i++) wr(8'h68, $urandom);
        run(20, 1, 0);
        // R8: read on the completion cycle keeps the word
        for (int i = 0; i < 3; i++) wr(8'h68, $urandom);
        run(20, 1, 1);
        // R7 drain partly, interleaved with more traffic
        for (int i = 0; i < 5; i++) rd(8'h6C);
        for (int i = 0; i < 4; i++) wr(8'h68, $urandom);
        run(30, 1, 2);

        // R3 slave mode
        spi_enable = 0; master_mode = 0; slave_sel_n = 1;
        for (int i = 0; i < 4; i++) wr(8'h68, $urandom);
        run(6, 1, 0);
        slave_sel_n = 0;
        run(40, 1, 0);
        run(25, 1, 2);
        rd(8'h6C);                                  // R9 empty again

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule